// File: doc/BRIEF.md
# Streaming Keystream Decryptor for Firmware Images

This block turns an encrypted firmware image back into plain bytes as it streams through. Bytes arrive one per transfer over a valid/ready handshake. The first two bytes of each image are a seed header: they set up the key generator and are consumed inside the block. Every byte after the header is combined by XOR with a fresh keystream byte, and the result leaves on an output valid/ready handshake.

The keystream comes from three registers that advance once per payload byte. The first is a 16-bit arithmetic state whose top bit drives every update. The second is an 8-bit selector register that picks a constant from a four-entry table. The third is an 8-bit Galois-style register that holds the keystream. The feedback is nonlinear: on a feedback step the state gets a constant added, plus a conditional correction of plus or minus 0x100. It does not use XOR taps.

A one-cycle synchronous start pulse sends the block back to header capture so that a new image can follow. The output side is a single register stage, so a byte accepted on one clock edge is offered downstream immediately after that edge.

Top module: `kstream_decrypt`

## Requirements
- R1: After reset or a start pulse, the first accepted byte is the seed high byte and the second is the seed low byte. Neither one produces an output byte, and out_valid stays low while the block is in the header phase.
- R2: When the seed low byte is accepted, the state becomes ({high,low} XOR 0x0081) + 1 modulo 2^16. The keystream register becomes low XOR 0x7E, and the selector register is cleared to 0x00.
- R3: For each payload byte, the block first takes bit 15 of the state as the feedback bit. It then shifts the state, the selector and the keystream register left by one bit. If the feedback bit is 1, the selector is XORed with 0x21 and 0xDF is added to the state modulo 2^16. If the feedback bit is 0, the shift is the only change.
- R4: On a feedback step, if bits [6:5] of the selector (after its XOR) equal binary 10, the state gets a further 0x100 added when selector bit 7 is 1. When selector bit 7 is 0, 0x100 is subtracted instead (modulo 2^16).
- R5: On a feedback step, the keystream register is XORed with a table entry chosen by selector bits [6:5] after the selector's XOR. The entries are 0x61, 0x21, 0xE1 and 0x21 for index 0, 1, 2 and 3.
- R6: Each output byte equals the payload byte XOR the updated keystream register XOR 0x7E. Bytes leave in the order they arrived, with none dropped or repeated.
- R7: A payload byte accepted on a clock edge is presented on out_valid/out_data right after that edge. While out_ready stays high, one byte is accepted every cycle.
- R8: In the payload phase, in_ready is low whenever a byte is pending and out_ready is low. A pending byte keeps its value until it is taken.
- R9: While start is high, in_ready and out_valid are low. On the following edge, any pending byte is discarded and the block is back in the header phase.
- R10: After reset, out_valid is low, in_ready is high and the block waits for a seed high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous pulse that begins a new image |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | DATA_W | Encrypted input byte |
| out_valid | output | 1 | Decrypted byte is offered |
| out_ready | input | 1 | Downstream takes the offered byte |
| out_data | output | DATA_W | Decrypted output byte |

## Verification
Each decrypted byte is due exactly one edge after its input handshake. The in_ready and out_valid flags are combinational from the phase, the pending flag, start and out_ready, so they are due in the same cycle the inputs change. The bench drives its inputs just after the falling edge and samples one nanosecond later. It predicts the coming rising edge from a behavioural model and a queue of expected bytes, and compares every cycle: ready, valid and, on each output handshake, the byte at the head of the queue. Start pulses and header bytes are checked at the same points, so a byte that appears a cycle early or late, or one that leaks out of the header phase, is reported in the cycle it happens.

// File: rtl/ksd_pkg.sv
package ksd_pkg;
   typedef enum logic [1:0] {
      PH_SEED_HI = 2'd0,
      PH_SEED_LO = 2'd1,
      PH_DATA    = 2'd2
   } ksd_phase_e;

   localparam int unsigned KSD_TBL_N  = 4;
   localparam int unsigned KSD_SEL_W  = 2;
   localparam logic [KSD_SEL_W-1:0] KSD_CORR_SEL = 2'b10;
endpackage

// File: rtl/ksd_phase_ctrl.sv
module ksd_phase_ctrl
   import ksd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       accept,
   output ksd_phase_e phase,
   output logic       hi_we,
   output logic       lo_we,
   output logic       data_we
);
   ksd_phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SEED_HI;
      end else if (start) begin
         phase_q <= PH_SEED_HI;
      end else if (accept) begin
         case (phase_q)
            PH_SEED_HI: phase_q <= PH_SEED_LO;
            PH_SEED_LO: phase_q <= PH_DATA;
            default:    phase_q <= PH_DATA;
         endcase
      end
   end

   assign phase   = phase_q;
   assign hi_we   = accept && !start && (phase_q == PH_SEED_HI);
   assign lo_we   = accept && !start && (phase_q == PH_SEED_LO);
   assign data_we = accept && !start && (phase_q == PH_DATA);
endmodule

// File: rtl/ksd_keystep.sv
module ksd_keystep
   import ksd_pkg::*;
#(
   parameter int unsigned           ST_W    = 16,
   parameter int unsigned           B_W     = 8,
   parameter int unsigned           SEL_LSB = 5,
   parameter bit                    CORR_EN = 1'b1,
   parameter logic [ST_W-1:0]       ADD_K   = 'h00DF,
   parameter logic [B_W-1:0]        SR_TAP  = 'h21,
   parameter logic [KSD_TBL_N*B_W-1:0] GAL_TBL = 'h21E12161
)(
   input  logic [ST_W-1:0] st_i,
   input  logic [B_W-1:0]  sr_i,
   input  logic [B_W-1:0]  gal_i,
   output logic [ST_W-1:0] st_o,
   output logic [B_W-1:0]  sr_o,
   output logic [B_W-1:0]  gal_o
);
   localparam logic [ST_W-1:0] CORR_STEP = ST_W'(1) << B_W;

   logic                 fb;
   logic [ST_W-1:0]      st_sh, st_add, st_fix;
   logic [B_W-1:0]       sr_sh, sr_tap, gal_sh, tbl_k;
   logic [KSD_SEL_W-1:0] sel;
   logic [B_W-1:0]       tbl_ent [KSD_TBL_N];

   assign fb     = st_i[ST_W-1];
   assign st_sh  = st_i << 1;
   assign sr_sh  = sr_i << 1;
   assign gal_sh = gal_i << 1;
   assign sr_tap = sr_sh ^ SR_TAP;
   assign sel    = sr_tap[SEL_LSB +: KSD_SEL_W];
   assign st_add = st_sh + ADD_K;

   for (genvar i = 0; i < KSD_TBL_N; i++) begin : g_tbl
      assign tbl_ent[i] = GAL_TBL[i*B_W +: B_W];
   end
   assign tbl_k = tbl_ent[sel];

   if (CORR_EN) begin : g_corr
      always_comb begin
         st_fix = st_add;
         if (sel == KSD_CORR_SEL) begin
            st_fix = sr_tap[B_W-1] ? (st_add + CORR_STEP) : (st_add - CORR_STEP);
         end
      end
   end else begin : g_nocorr
      assign st_fix = st_add;
   end

   assign st_o  = fb ? st_fix : st_sh;
   assign sr_o  = fb ? sr_tap : sr_sh;
   assign gal_o = fb ? (gal_sh ^ tbl_k) : gal_sh;
endmodule

// File: rtl/ksd_keyregs.sv
module ksd_keyregs
   import ksd_pkg::*;
#(
   parameter int unsigned           ST_W     = 16,
   parameter int unsigned           B_W      = 8,
   parameter int unsigned           SEL_LSB  = 5,
   parameter bit                    CORR_EN  = 1'b1,
   parameter logic [ST_W-1:0]       SEED_XOR = 'h0081,
   parameter logic [ST_W-1:0]       SEED_INC = 'h0001,
   parameter logic [ST_W-1:0]       ADD_K    = 'h00DF,
   parameter logic [B_W-1:0]        SR_TAP   = 'h21,
   parameter logic [B_W-1:0]        OUT_MASK = 'h7E,
   parameter logic [KSD_TBL_N*B_W-1:0] GAL_TBL = 'h21E12161
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hi_we,
   input  logic           lo_we,
   input  logic           data_we,
   input  logic [B_W-1:0] din,
   output logic [B_W-1:0] ks_byte
);
   logic [B_W-1:0]  seed_hi_q;
   logic [ST_W-1:0] st_q, st_n;
   logic [B_W-1:0]  sr_q, sr_n, gal_q, gal_n;
   logic [ST_W-1:0] seed_w;

   assign seed_w = ST_W'({seed_hi_q, din});

   ksd_keystep #(
      .ST_W(ST_W), .B_W(B_W), .SEL_LSB(SEL_LSB), .CORR_EN(CORR_EN),
      .ADD_K(ADD_K), .SR_TAP(SR_TAP), .GAL_TBL(GAL_TBL)
   ) u_step (
      .st_i(st_q), .sr_i(sr_q), .gal_i(gal_q),
      .st_o(st_n), .sr_o(sr_n), .gal_o(gal_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_hi_q <= '0;
         st_q      <= '0;
         sr_q      <= '0;
         gal_q     <= '0;
      end else begin
         if (hi_we) seed_hi_q <= din;
         if (lo_we) begin
            st_q  <= (seed_w ^ SEED_XOR) + SEED_INC;
            sr_q  <= '0;
            gal_q <= din ^ OUT_MASK;
         end else if (data_we) begin
            st_q  <= st_n;
            sr_q  <= sr_n;
            gal_q <= gal_n;
         end
      end
   end

   assign ks_byte = gal_n ^ OUT_MASK;
endmodule

// File: rtl/ksd_out_stage.sv
module ksd_out_stage #(
   parameter int unsigned B_W = 8
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           load,
   input  logic [B_W-1:0] din,
   input  logic           out_ready,
   output logic           out_valid,
   output logic [B_W-1:0] out_data,
   output logic           pend
);
   logic           vld_q;
   logic [B_W-1:0] dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (start) begin
         vld_q <= 1'b0;
      end else if (load) begin
         vld_q <= 1'b1;
         dat_q <= din;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   assign out_valid = vld_q && !start;
   assign out_data  = dat_q;
   assign pend      = vld_q;
endmodule

// File: rtl/kstream_decrypt.sv
module kstream_decrypt
   import ksd_pkg::*;
#(
   parameter int unsigned           DATA_W    = 8,
   parameter int unsigned           STATE_W   = 16,
   parameter int unsigned           SEL_LSB   = 5,
   parameter bit                    CORR_EN   = 1'b1,
   parameter logic [STATE_W-1:0]    SEED_XOR  = 'h0081,
   parameter logic [STATE_W-1:0]    SEED_INC  = 'h0001,
   parameter logic [STATE_W-1:0]    STATE_ADD = 'h00DF,
   parameter logic [DATA_W-1:0]     SR_TAP    = 'h21,
   parameter logic [DATA_W-1:0]     OUT_MASK  = 'h7E,
   parameter logic [KSD_TBL_N*DATA_W-1:0] GAL_TBL = 'h21E12161
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   if (SEL_LSB + KSD_SEL_W >= DATA_W) begin : g_bad_sel
      $error("selector field must sit below the sign bit of the byte");
   end
   if (STATE_W < 2 * DATA_W) begin : g_bad_state
      $error("state must hold a two-byte seed");
   end

   ksd_phase_e        phase;
   logic              hi_we, lo_we, data_we, accept, pend, hdr_phase;
   logic [DATA_W-1:0] ks_byte, plain;

   assign hdr_phase = (phase != PH_DATA);
   assign in_ready  = !start && (hdr_phase || !pend || out_ready);
   assign accept    = in_valid && in_ready;
   assign plain     = in_data ^ ks_byte;

   ksd_phase_ctrl u_phase (
      .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
      .phase(phase), .hi_we(hi_we), .lo_we(lo_we), .data_we(data_we)
   );

   ksd_keyregs #(
      .ST_W(STATE_W), .B_W(DATA_W), .SEL_LSB(SEL_LSB), .CORR_EN(CORR_EN),
      .SEED_XOR(SEED_XOR), .SEED_INC(SEED_INC), .ADD_K(STATE_ADD),
      .SR_TAP(SR_TAP), .OUT_MASK(OUT_MASK), .GAL_TBL(GAL_TBL)
   ) u_keys (
      .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we),
      .data_we(data_we), .din(in_data), .ks_byte(ks_byte)
   );

   ksd_out_stage #(.B_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .start(start), .load(data_we),
      .din(plain), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .pend(pend)
   );
endmodule

// File: rtl/ksd_checker.sv
module ksd_checker #(
   parameter int unsigned B_W = 8
)(
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           in_valid,
   input logic           in_ready,
   input logic           out_valid,
   input logic           out_ready,
   input logic [B_W-1:0] out_data,
   input logic           hdr_phase
);
   p_hdr_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_phase |-> !out_valid);

   p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !hdr_phase) |=> (out_valid || start));

   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hdr_phase && out_valid && !out_ready) |-> !in_ready);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (start || (out_valid && $stable(out_data))));

   p_start_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!in_ready && !out_valid));

   p_start_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (hdr_phase && !out_valid));
endmodule

bind kstream_decrypt ksd_checker #(.B_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
   .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .hdr_phase(hdr_phase)
);

// File: tb/kstream_decrypt_tb.sv
module kstream_decrypt_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_ready = 1'b0;
   logic       in_ready, out_valid;
   logic [7:0] out_data;

   int checks = 0;
   int failures = 0;
   int stall_in_payload = 0;

   int unsigned m_st, m_sr, m_gal, m_hi;
   int m_cnt = 0;
   int unsigned expq[$];

   always #4 clk = ~clk;

   kstream_decrypt u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   task automatic check(input string tag, input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural model of one payload byte (R3, R4, R5, R6)
   function automatic int unsigned model_byte(input int unsigned d);
      int unsigned idx;
      bit fb;
      fb    = ((m_st >> 15) & 1) == 1;
      m_st  = (m_st * 2) % 65536;
      m_sr  = (m_sr * 2) % 256;
      m_gal = (m_gal * 2) % 256;
      if (fb) begin
         m_sr = m_sr ^ 'h21;
         m_st = (m_st + 'hDF) % 65536;
         idx  = (m_sr / 32) % 4;
         if (idx == 2) begin
            if (m_sr >= 128) m_st = (m_st + 256) % 65536;
            else             m_st = (m_st + 65536 - 256) % 65536;
         end
         case (idx)
            0: m_gal = m_gal ^ 'h61;
            2: m_gal = m_gal ^ 'hE1;
            default: m_gal = m_gal ^ 'h21;
         endcase
      end
      return (d ^ m_gal ^ 'h7E) % 256;
   endfunction

   task automatic cycle(input bit st, input bit vld, input int unsigned d, input bit ordy);
      bit exp_ir, exp_ov;
      @(negedge clk);
      start = st; in_valid = vld; in_data = d[7:0]; out_ready = ordy;
      #1;
      exp_ir = !st && (m_cnt < 2 || expq.size() == 0 || ordy);
      exp_ov = !st && expq.size() != 0;
      check("R8 R9 R1 in_ready", in_ready, exp_ir);
      check("R7 R9 R1 out_valid", out_valid, exp_ov);
      if (m_cnt >= 2 && !in_ready && !st) stall_in_payload++;
      if (exp_ov && ordy) begin
         check("R6 R2 R3 R4 R5 out_data", out_data, expq[0]);
         void'(expq.pop_front());
      end
      if (st) begin
         expq.delete();
         m_cnt = 0;
      end else if (vld && exp_ir) begin
         if (m_cnt == 0) begin
            m_hi = d % 256;
            m_cnt = 1;
         end else if (m_cnt == 1) begin
            m_st  = (((m_hi * 256 + d % 256) ^ 'h81) + 1) % 65536;
            m_gal = (d % 256) ^ 'h7E;
            m_sr  = 0;
            m_cnt = 2;
         end else begin
            expq.push_back(model_byte(d % 256));
         end
      end
   endtask

   task automatic image(input int unsigned hi, input int unsigned lo, input int n,
                        input int vld_pct, input int rdy_pct);
      int sent;
      cycle(1'b1, 1'b0, 0, 1'b1);
      cycle(1'b0, 1'b1, hi, 1'b1);
      cycle(1'b0, 1'b1, lo, 1'b1);
      sent = 0;
      while (sent < n) begin
         bit v, r;
         int unsigned d;
         v = ($urandom_range(99) < vld_pct);
         r = ($urandom_range(99) < rdy_pct);
         d = $urandom_range(255);
         if (v && (expq.size() == 0 || r)) sent++;
         cycle(1'b0, v, d, r);
      end
      for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 0, 1'b1);
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R10 reset out_valid", out_valid, 0);
      check("R10 reset in_ready", in_ready, 1);

      // R1: header bytes from reset produce no output
      cycle(1'b0, 1'b1, 'h03, 1'b1);
      cycle(1'b0, 1'b1, 'hAB, 1'b1);
      cycle(1'b0, 1'b0, 0, 1'b1);
      // R7: continuous stream, one byte per cycle
      stall_in_payload = 0;
      for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, i * 7, 1'b1);
      check("R7 no stall with out_ready high", stall_in_payload, 0);
      for (int k = 0; k < 2; k++) cycle(1'b0, 1'b0, 0, 1'b1);

      // R2..R6 under random backpressure, several seeds
      image('h03, 'hA4, 300, 70, 60);
      image('hFF, 'hFF, 80, 100, 100);
      image('h00, 'h00, 80, 50, 30);
      image('h80, 'h7E, 200, 90, 80);

      // R8: stall with a byte pending, then R9: start drops it
      cycle(1'b1, 1'b0, 0, 1'b0);
      cycle(1'b0, 1'b1, 'h12, 1'b0);
      cycle(1'b0, 1'b1, 'h34, 1'b0);
      for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 'h55 + i, 1'b0);
      cycle(1'b1, 1'b1, 'h99, 1'b1);
      cycle(1'b0, 1'b0, 0, 1'b1);
      check("R9 out_valid after start", out_valid, 0);

      // R9: start in the middle of the header
      cycle(1'b0, 1'b1, 'hC3, 1'b1);
      cycle(1'b1, 1'b1, 'h3C, 1'b1);
      image('h5A, 'hA5, 60, 80, 90);

      // R6: all-zero payload exposes the raw keystream
      cycle(1'b1, 1'b0, 0, 1'b1);
      cycle(1'b0, 1'b1, 'h03, 1'b1);
      cycle(1'b0, 1'b1, 'hAA, 1'b1);
      for (int i = 0; i < 64; i++) cycle(1'b0, 1'b1, 0, 1'b1);
      for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 0, 1'b1);

      check("R6 no byte left undelivered", expq.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule